// File: doc/BRIEF.md
# Multi-Pin External Interrupt Controller

This block turns the levels of interrupt-capable I/O pins into per-vector interrupt requests for a CPU. The pins are split into fixed groups, one group per vector. A pin takes part only when it is configured as an input and its option bit is set. The enabled pins of a group are AND-combined into one signal per vector. A disabled pin counts as a logic 1, so only an enabled pin can mask its neighbours.

Each vector has its own two-bit sensitivity setting. The setting picks rising edge, falling edge, both edges, or falling edge plus low level. When the selected event occurs, a request latch sets, and the latch drives that vector's request line. The CPU clears a request by returning an acknowledge that carries the vector index. Writing a vector's sensitivity also clears any request pending on that vector. Pin levels arrive already synchronized. Priority between vectors is decided outside the block.

Top module: `eint_ctrl`

## Requirements
- R1: A pin is enabled only when its direction bit is 0 (input) and its option bit is 1. Pins that are not enabled have no effect on any request.
- R2: Vector v owns pins v*PINS_PER_VEC to v*PINS_PER_VEC+PINS_PER_VEC-1. Its combined signal is the AND of its enabled pins, with disabled pins counted as 1. An enabled pin held low therefore hides edges on the other pins of the group.
- R3: Sensitivity 2'b01 sets the request on a rising edge of the combined signal only. The request line rises at the first clock edge after the pin change is presented. A request never sets without its selected event.
- R4: Sensitivity 2'b10 sets the request on falling edges only. Sensitivity 2'b11 sets it on both edges. A set request stays high until it is cleared.
- R5: Sensitivity 2'b00 sets the request on a falling edge and also while the combined signal is low. If the signal is still low when an acknowledge arrives, the request drops for one cycle and then sets again.
- R6: An acknowledge with index v clears only vector v's request, at the next clock edge.
- R7: A sensitivity write to vector v clears v's pending request at the next clock edge. This holds even if an event occurs in the same cycle. Other vectors are not affected.
- R8: If an acknowledge and a selected edge on the same vector occur in the same cycle, the request stays set.
- R9: Reset clears all requests and selects sensitivity 2'b00 on every vector. Reset also takes each vector's previous combined level as high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_level | input | NUM_VEC*PINS_PER_VEC | Synchronized pin levels |
| pin_dir_out | input | NUM_VEC*PINS_PER_VEC | Per-pin direction, 1 = output |
| pin_opt | input | NUM_VEC*PINS_PER_VEC | Per-pin option bit, 1 = interrupt enabled in input mode |
| sens_wr_en | input | 1 | Sensitivity write strobe |
| sens_wr_vec | input | VEC_W | Vector index of the sensitivity write |
| sens_wr_mode | input | 2 | New sensitivity code |
| ack_valid | input | 1 | Acknowledge strobe from the CPU |
| ack_vec | input | VEC_W | Vector index being acknowledged |
| irq_req | output | NUM_VEC | Per-vector pending request |

## Verification
Every result is due at the first rising clock edge after its stimulus is applied. This covers an edge-set request, an acknowledge clear, and a clear caused by a sensitivity write. The one exception is the level re-set after an acknowledge, which appears one edge later. The bench applies each stimulus just after a rising edge and steps exactly one edge. It then compares the request lines 1 ns later, well away from the next edge. The level re-set case uses a separate table row, so that row's expected value already contains the one-cycle gap.

// File: rtl/eint_pkg.sv
package eint_pkg;

    typedef enum logic [1:0] {
        SENSE_FALL_LOW = 2'b00,
        SENSE_RISE     = 2'b01,
        SENSE_FALL     = 2'b10,
        SENSE_BOTH     = 2'b11
    } sense_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic low;
    } evt_t;

    typedef struct packed {
        logic sens_wr;
        logic ack;
    } clr_t;

    function automatic logic edge_event(input sense_e mode, input evt_t evt);
        logic hit;
        case (mode)
            SENSE_FALL_LOW: hit = evt.fall;
            SENSE_RISE:     hit = evt.rise;
            SENSE_FALL:     hit = evt.fall;
            default:        hit = evt.rise | evt.fall;
        endcase
        return hit;
    endfunction

    function automatic logic level_event(input sense_e mode, input evt_t evt);
        return (mode == SENSE_FALL_LOW) && evt.low;
    endfunction

endpackage

// File: rtl/eint_pin_merge.sv
module eint_pin_merge #(
    parameter int PINS_PER_VEC = 3
) (
    input  logic [PINS_PER_VEC-1:0] lvl,
    input  logic [PINS_PER_VEC-1:0] dir_out,
    input  logic [PINS_PER_VEC-1:0] opt,
    output logic                    merged
);
    logic [PINS_PER_VEC-1:0] enabled;
    logic [PINS_PER_VEC-1:0] contrib;

    // input mode with option set; disabled pins read as 1 in the AND
    always_comb begin
        enabled = ~dir_out & opt;
        contrib = lvl | ~enabled;
        merged  = &contrib;
    end
endmodule

// File: rtl/eint_edge_det.sv
module eint_edge_det
    import eint_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic merged,
    output evt_t evt
);
    logic merged_q;

    always_ff @(posedge clk) begin
        if (rst) merged_q <= 1'b1;
        else     merged_q <= merged;
    end

    always_comb begin
        evt.rise = merged & ~merged_q;
        evt.fall = ~merged & merged_q;
        evt.low  = ~merged;
    end
endmodule

// File: rtl/eint_req_latch.sv
module eint_req_latch
    import eint_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  evt_t       evt,
    input  clr_t       clr,
    input  logic [1:0] wr_mode,
    output logic       pend
);
    sense_e mode_q;
    logic   pend_q;
    logic   hit_edge;
    logic   hit_level;

    always_comb begin
        hit_edge  = edge_event(mode_q, evt);
        hit_level = level_event(mode_q, evt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= SENSE_FALL_LOW;
        end else if (clr.sens_wr) begin
            mode_q <= sense_e'(wr_mode);
        end
    end

    // priority: sensitivity write, edge, acknowledge, level
    always_ff @(posedge clk) begin
        if (rst)            pend_q <= 1'b0;
        else if (clr.sens_wr) pend_q <= 1'b0;
        else if (hit_edge)  pend_q <= 1'b1;
        else if (clr.ack)   pend_q <= 1'b0;
        else if (hit_level) pend_q <= 1'b1;
    end

    assign pend = pend_q;

    AST_SENS_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        clr.sens_wr |=> !pend_q) else $error("sens write did not clear"); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (clr.ack && !hit_edge && !clr.sens_wr) |=> !pend_q) else $error("ack did not clear"); // R6
    AST_EDGE_BEATS_ACK: assert property (@(posedge clk) disable iff (rst)
        (clr.ack && hit_edge && !clr.sens_wr) |=> pend_q) else $error("edge lost to ack"); // R8
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
        (!pend_q && !hit_edge && !hit_level) |=> !pend_q) else $error("spurious request"); // R3
endmodule

// File: rtl/eint_ctrl.sv
module eint_ctrl
    import eint_pkg::*;
#(
    parameter int NUM_VEC      = 4,
    parameter int PINS_PER_VEC = 3,
    localparam int NUM_PINS    = NUM_VEC * PINS_PER_VEC,
    localparam int VEC_W       = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_level,
    input  logic [NUM_PINS-1:0] pin_dir_out,
    input  logic [NUM_PINS-1:0] pin_opt,
    input  logic                sens_wr_en,
    input  logic [VEC_W-1:0]    sens_wr_vec,
    input  logic [1:0]          sens_wr_mode,
    input  logic                ack_valid,
    input  logic [VEC_W-1:0]    ack_vec,
    output logic [NUM_VEC-1:0]  irq_req
);
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        logic merged;
        evt_t evt;
        clr_t clr;

        eint_pin_merge #(.PINS_PER_VEC(PINS_PER_VEC)) u_merge (
            .lvl     (pin_level  [v*PINS_PER_VEC +: PINS_PER_VEC]),
            .dir_out (pin_dir_out[v*PINS_PER_VEC +: PINS_PER_VEC]),
            .opt     (pin_opt    [v*PINS_PER_VEC +: PINS_PER_VEC]),
            .merged  (merged)
        );

        eint_edge_det u_edge (
            .clk    (clk),
            .rst    (rst),
            .merged (merged),
            .evt    (evt)
        );

        always_comb begin
            clr.sens_wr = sens_wr_en && (sens_wr_vec == VEC_W'(v));
            clr.ack     = ack_valid  && (ack_vec     == VEC_W'(v));
        end

        eint_req_latch u_latch (
            .clk     (clk),
            .rst     (rst),
            .evt     (evt),
            .clr     (clr),
            .wr_mode (sens_wr_mode),
            .pend    (irq_req[v])
        );
    end
endmodule

// File: tb/eint_ctrl_bench.sv
module eint_ctrl_bench;
    localparam int NV  = 4;
    localparam int PPV = 3;
    localparam int NP  = NV * PPV;
    localparam int NROWS = 37;

    typedef struct packed {
        logic [11:0] pins;
        logic [11:0] dir;
        logic [11:0] opt;
        logic        swe;
        logic [1:0]  svec;
        logic [1:0]  smode;
        logic        ackv;
        logic [1:0]  ackvec;
        logic [3:0]  exp;
        logic [3:0]  req;
    } row_t;

    // pins, dir, opt, swe, svec, smode, ackv, ackvec, expected irq_req, requirement
    localparam row_t TBL [NROWS] = '{
        '{12'hFFF, 12'h000, 12'hFFF, 1'b1, 2'd0, 2'd1, 1'b0, 2'd0, 4'h0, 4'd7}, // R7 vec0 rise
        '{12'hFFF, 12'h000, 12'hFFF, 1'b1, 2'd1, 2'd2, 1'b0, 2'd0, 4'h0, 4'd7}, // R7 vec1 fall
        '{12'hFFF, 12'h000, 12'hFFF, 1'b1, 2'd2, 2'd3, 1'b0, 2'd0, 4'h0, 4'd7}, // R7 vec2 both
        '{12'hFFE, 12'h000, 12'hFFF, 1'b0, 2'd0, 2'd0, 1'b0, 2'd0, 4'h0, 4'd3}, // R3 fall ignored
        '{12'hFFF, 12'h000, 12'hFFF, 1'b0, 2'd0, 2'd0, 1'b0, 2'd0, 4'h1, 4'd3}, // R3 rise sets
        '{12'hFFF, 12'h000, 12'hFFF, 1'b0, 2'd0, 2'd0, 1'b0, 2'd0, 4'h1, 4'd3}, // R3 holds
        '{12'hFFF, 12'h000, 12'hFFF, 1'b0, 2'd0, 2'd0, 1'b1, 2'd0, 4'h0, 4'd6}, // R6 ack0
        '{12'hFF7, 12'h000, 12'hFFF, 1'b0, 2'd0, 2'd0, 1'b0, 2'd0, 4'h2, 4'd4}, // R4 fall vec1
        '{12'hFFF, 12'h000, 12'hFFF, 1'b0, 2'd0, 2'd0, 1'b0, 2'd0, 4'h2, 4'd4}, // R4 rise ignored
        '{12'hFFF, 12'h000, 12'hFFF, 1'b0, 2'd0, 2'd0, 1'b1, 2'd1, 4'h0, 4'd6}, // R6 ack1
        '{12'hFBF, 12'h000, 12'hFFF, 1'b0, 2'd0, 2'd0, 1'b0, 2'd0, 4'h4, 4'd4}, // R4 both: fall
        '{12'hFFF, 12'h000, 12'hFFF, 1'b0, 2'd0, 2'd0, 1'b1, 2'd2, 4'h4, 4'd8}, // R8 rise with ack
        '{12'hFFF, 12'h000, 12'hFFF, 1'b0, 2'd0, 2'd0, 1'b1, 2'd2, 4'h0, 4'd6}, // R6 ack2
        '{12'hDFF, 12'h000, 12'hFFF, 1'b0, 2'd0, 2'd0, 1'b0, 2'd0, 4'h8, 4'd5}, // R5 fall vec3
        '{12'hDFF, 12'h000, 12'hFFF, 1'b0, 2'd0, 2'd0, 1'b1, 2'd3, 4'h0, 4'd5}, // R5 ack drops
        '{12'hDFF, 12'h000, 12'hFFF, 1'b0, 2'd0, 2'd0, 1'b0, 2'd0, 4'h8, 4'd5}, // R5 level resets
        '{12'hDFF, 12'h000, 12'hFFF, 1'b1, 2'd3, 2'd0, 1'b0, 2'd0, 4'h0, 4'd7}, // R7 write beats level
        '{12'hFFF, 12'h000, 12'hFFF, 1'b0, 2'd0, 2'd0, 1'b0, 2'd0, 4'h0, 4'd5}, // R5 rise no set
        '{12'hFFD, 12'h000, 12'hFFF, 1'b0, 2'd0, 2'd0, 1'b0, 2'd0, 4'h0, 4'd3}, // R3 pin1 low
        '{12'hFFC, 12'h000, 12'hFFF, 1'b0, 2'd0, 2'd0, 1'b0, 2'd0, 4'h0, 4'd2}, // R2 both low
        '{12'hFFD, 12'h000, 12'hFFF, 1'b0, 2'd0, 2'd0, 1'b0, 2'd0, 4'h0, 4'd2}, // R2 pin0 rise masked
        '{12'hFFF, 12'h000, 12'hFFF, 1'b0, 2'd0, 2'd0, 1'b0, 2'd0, 4'h1, 4'd2}, // R2 group rises
        '{12'hFFF, 12'h000, 12'hFFF, 1'b0, 2'd0, 2'd0, 1'b1, 2'd0, 4'h0, 4'd6}, // R6 ack0
        '{12'hFEF, 12'h000, 12'hFEF, 1'b0, 2'd0, 2'd0, 1'b0, 2'd0, 4'h0, 4'd1}, // R1 opt off
        '{12'hFFF, 12'h000, 12'hFFF, 1'b0, 2'd0, 2'd0, 1'b0, 2'd0, 4'h0, 4'd1}, // R1 restore
        '{12'hFEF, 12'h010, 12'hFFF, 1'b0, 2'd0, 2'd0, 1'b0, 2'd0, 4'h0, 4'd1}, // R1 output mode
        '{12'hFEF, 12'h000, 12'hFFF, 1'b0, 2'd0, 2'd0, 1'b0, 2'd0, 4'h2, 4'd1}, // R1 back to input
        '{12'hFFF, 12'h000, 12'hFFF, 1'b0, 2'd0, 2'd0, 1'b1, 2'd1, 4'h0, 4'd6}, // R6 ack1
        '{12'hFBF, 12'h000, 12'hFFF, 1'b0, 2'd0, 2'd0, 1'b0, 2'd0, 4'h4, 4'd4}, // R4 fall vec2
        '{12'hFBF, 12'h000, 12'hFFF, 1'b1, 2'd0, 2'd1, 1'b0, 2'd0, 4'h4, 4'd7}, // R7 other vector kept
        '{12'hFBF, 12'h000, 12'hFFF, 1'b1, 2'd2, 2'd3, 1'b0, 2'd0, 4'h0, 4'd7}, // R7 own vector cleared
        '{12'hFFF, 12'h000, 12'hFFF, 1'b0, 2'd0, 2'd0, 1'b0, 2'd0, 4'h4, 4'd4}, // R4 rise vec2
        '{12'hFFF, 12'h000, 12'hFFF, 1'b0, 2'd0, 2'd0, 1'b1, 2'd2, 4'h0, 4'd6}, // R6 ack2
        '{12'hFB7, 12'h000, 12'hFFF, 1'b0, 2'd0, 2'd0, 1'b0, 2'd0, 4'h6, 4'd6}, // R6 two pending
        '{12'hFB7, 12'h000, 12'hFFF, 1'b0, 2'd0, 2'd0, 1'b1, 2'd1, 4'h4, 4'd6}, // R6 only vec1 cleared
        '{12'hFFF, 12'h000, 12'hFFF, 1'b0, 2'd0, 2'd0, 1'b1, 2'd2, 4'h4, 4'd8}, // R8 rise with ack
        '{12'hFFF, 12'h000, 12'hFFF, 1'b0, 2'd0, 2'd0, 1'b1, 2'd2, 4'h0, 4'd6}  // R6 ack2
    };

    logic          clk = 1'b0;
    logic          rst;
    logic [NP-1:0] pin_level;
    logic [NP-1:0] pin_dir_out;
    logic [NP-1:0] pin_opt;
    logic          sens_wr_en;
    logic [1:0]    sens_wr_vec;
    logic [1:0]    sens_wr_mode;
    logic          ack_valid;
    logic [1:0]    ack_vec;
    logic [NV-1:0] irq_req;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    eint_ctrl #(.NUM_VEC(NV), .PINS_PER_VEC(PPV)) u_eint_ctrl (
        .clk, .rst, .pin_level, .pin_dir_out, .pin_opt,
        .sens_wr_en, .sens_wr_vec, .sens_wr_mode,
        .ack_valid, .ack_vec, .irq_req
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [NV-1:0] exp);
        n_vec++;
        if (irq_req !== exp) begin
            n_fail++;
            $display("FAIL %s: irq_req=%b expected %b", tag, irq_req, exp);
        end
    endtask

    task automatic idle_inputs();
        sens_wr_en = 1'b0; sens_wr_vec = '0; sens_wr_mode = '0;
        ack_valid = 1'b0; ack_vec = '0;
    endtask

    initial begin
        rst = 1'b1;
        pin_level = '1; pin_dir_out = '0; pin_opt = '0;
        idle_inputs();
        step(); step();
        check("R9 reset", 4'h0);
        rst = 1'b0;
        step();
        check("R9 after release", 4'h0);

        for (int i = 0; i < NROWS; i++) begin
            pin_level    = TBL[i].pins;
            pin_dir_out  = TBL[i].dir;
            pin_opt      = TBL[i].opt;
            sens_wr_en   = TBL[i].swe;
            sens_wr_vec  = TBL[i].svec;
            sens_wr_mode = TBL[i].smode;
            ack_valid    = TBL[i].ackv;
            ack_vec      = TBL[i].ackvec;
            step();
            check($sformatf("R%0d row %0d", TBL[i].req, i), TBL[i].exp);
        end

        // R9: reset restores sensitivity 00 and takes previous level as high
        idle_inputs();
        pin_level = '1; pin_opt = '1;
        rst = 1'b1;
        step();
        check("R9 reset mid-run", 4'h0);
        pin_level = 12'hDFE;
        step();
        check("R9 reset holds low pins", 4'h0);
        rst = 1'b0;
        step();
        check("R9 default falling-low mode", 4'h9);
        ack_valid = 1'b1; ack_vec = 2'd0;
        step();
        check("R5 ack with level held", 4'h8);
        ack_valid = 1'b0;
        step();
        check("R5 level sets again", 4'h9);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run incomplete, requirement checks R1 to R9 not finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule